// File: doc/BRIEF.md
# ECC RAM with Hardware Zero-Fill Engine

A single-error-correcting, double-error-detecting on-chip RAM with one or two independent access ports. Each word holds 32 data bits and 7 check bits. Because an uninitialised array holds arbitrary check bits, each port has its own hardware engine. When software starts it, the engine walks every address of that port's array and writes all-zero data together with all-zero check bits. The all-zero pattern is itself a valid codeword, so later reads of untouched words are clean.

A small register file sits beside the RAM. It holds per-port ECC enables and engine starts, per-port completion flags, a single-bit-error interrupt enable with set and clear aliases, an interrupt mode bit, and write-one-to-clear error pending flags. Software normally turns ECC off, runs the engine, and then turns ECC back on. With ECC off, a write updates only the data bits and reads return raw data, so the engine's result and the enable sequencing never depend on the check logic. A single level interrupt line collects the pending flags.

Top module: `ecc_ram`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and every `ready_o` bit is high.
- R2: With ECC enabled for a port, a write followed by a read of the same address returns the written data with no error flag. `rvalid_o` is high in the cycle after an accepted read request.
- R3: Writing 1 to control bit 16 (port A) or bit 17 (port B) at offset 0x08 zero-fills every word of that port in exactly DEPTH cycles. `ready_o` is low for those cycles, requests in that time are ignored (no `rvalid_o`), and afterwards every word reads 0 with no error.
- R4: The completion flags sit at offset 0x0C, bit 0 for port A and bit 8 for port B. A flag goes to 1 when its pass ends. A new start clears the flag. A start written while that port is busy is ignored and does not lengthen the pass.
- R5: With a port's ECC enable clear, a write changes only the data bits and keeps the stored check bits. A read returns the raw stored data.
- R6: With ECC enabled, a stored word with one flipped bit is read back corrected, and bit p of the status register at offset 0x20 is set (p = 0 for port A, 1 for port B).
- R7: With ECC enabled, a word with two flipped bits sets status bit 8+p. Any set double-error bit drives `irq_o` high whatever the enable is.
- R8: Bit 0 of offset 0x10 is the single-error interrupt enable. Writing 1 to bit 0 of offset 0x14 sets it, and writing 1 to bit 0 of offset 0x18 clears it. `irq_o` is high when a single-error pending bit is set and the enable is 1.
- R9: Writing 1 to a bit of offset 0x20 clears that pending bit. Writing 0 leaves it unchanged.
- R10: Mode bit 0 at offset 0x1C is 1: a single-bit error on a port whose pending bit is already set drops `irq_o` for exactly one cycle, giving a fresh edge. Mode bit is 0: `irq_o` stays high.
- R11: Offset 0x08 bits [1:0] are the ECC enables for ports A and B and read back as written. The start bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from offset) |
| req_i | input | NUM_PORTS | Per-port access request |
| we_i | input | NUM_PORTS | Per-port write select |
| addr_i | input | NUM_PORTS x ADDR_W | Per-port word address |
| wdata_i | input | NUM_PORTS x 32 | Per-port write data |
| ready_o | output | NUM_PORTS | Port accepts requests (low during zero-fill) |
| rvalid_o | output | NUM_PORTS | Read data valid |
| rdata_o | output | NUM_PORTS x 32 | Read data (corrected when ECC enabled) |
| irq_o | output | 1 | Interrupt |

## Verification
A fault in the zero-fill address counter or busy flag shows at `ready_o` within DEPTH+1 cycles. It appears as a pass of the wrong length or as a restart on a repeated start, and it leaves nonzero or flagged words that a read exposes one cycle later. A wrong syndrome or correction map shows as wrong `rdata_o` in the cycle after the read. A wrong pending flag appears at offset 0x20 one cycle after that. Interrupt enable, alias and mode faults appear on `irq_o` within two cycles of the causing read or register write.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
  localparam int DW = 32;
  localparam int HW = 6;
  localparam int CW = HW + 1;
  localparam int CODE_POS = DW + HW;

  localparam logic [5:0] OFS_CTRL    = 6'h08;
  localparam logic [5:0] OFS_DONE    = 6'h0C;
  localparam logic [5:0] OFS_IEN     = 6'h10;
  localparam logic [5:0] OFS_IEN_SET = 6'h14;
  localparam logic [5:0] OFS_IEN_CLR = 6'h18;
  localparam logic [5:0] OFS_IMODE   = 6'h1C;
  localparam logic [5:0] OFS_ISTAT   = 6'h20;

  localparam int START_BIT = 16;
  localparam int DBE_BIT   = 8;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          sbe;
    logic          dbe;
  } dec_t;

  // Hamming positions 1..CODE_POS, parity at powers of two, plus overall parity in top bit
  function automatic logic [CW-1:0] ecc_enc(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    int idx;
    h   = '0;
    idx = 0;
    for (int pos = 1; pos <= CODE_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int k = 0; k < HW; k++)
          if (pos[k]) h[k] = h[k] ^ d[idx[4:0]];
        idx++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic dec_t ecc_dec(input logic [DW-1:0] d, input logic [CW-1:0] c);
    dec_t r;
    logic [CW-1:0] e;
    logic [HW-1:0] syn;
    logic par;
    int idx;
    e   = ecc_enc(d);
    syn = e[HW-1:0] ^ c[HW-1:0];
    par = ^{d, c};
    r.data = d;
    r.sbe  = par;
    r.dbe  = !par && (syn != '0);
    idx = 0;
    for (int pos = 1; pos <= CODE_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (par && syn == pos[HW-1:0]) r.data[idx[4:0]] = ~d[idx[4:0]];
        idx++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_ram_port.sv
module ecc_ram_port
  import ecc_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ecc_en_i,
  input  logic          init_start_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          sbe_o,
  output logic          dbe_o,
  output logic          done_o
);
  localparam int WW = DW + CW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WW-1:0] mem_q [DEPTH];
  logic [WW-1:0] rd_q;
  logic          busy_q, done_q, rvalid_q;
  logic [AW-1:0] iaddr_q;
  logic          acc;
  dec_t          dec;

  assign acc = req_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      iaddr_q <= '0;
    end else if (init_start_i && !busy_q) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      iaddr_q <= '0;
    end else if (busy_q) begin
      iaddr_q <= iaddr_q + 1'b1;
      if (iaddr_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // ECC off: data bits only, stored check bits kept
  always_ff @(posedge clk_i) begin
    if (busy_q) mem_q[iaddr_q] <= '0;
    else if (acc && we_i)
      mem_q[addr_i] <= ecc_en_i ? {ecc_enc(wdata_i), wdata_i}
                                : {mem_q[addr_i][WW-1:DW], wdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      rvalid_q <= acc && !we_i;
      if (acc && !we_i) rd_q <= mem_q[addr_i];
    end
  end

  assign dec      = ecc_dec(rd_q[DW-1:0], rd_q[WW-1:DW]);
  assign rdata_o  = ecc_en_i ? dec.data : rd_q[DW-1:0];
  assign sbe_o    = rvalid_q && ecc_en_i && dec.sbe;
  assign dbe_o    = rvalid_q && ecc_en_i && dec.dbe;
  assign rvalid_o = rvalid_q;
  assign ready_o  = !busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ecc_ram_regs.sv
module ecc_ram_regs
  import ecc_ram_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NP-1:0] done_i,
  input  logic [NP-1:0] sbe_i,
  input  logic [NP-1:0] dbe_i,
  output logic [NP-1:0] ecc_en_o,
  output logic [NP-1:0] init_start_o,
  output logic          irq_o
);
  logic [NP-1:0] ecc_en_q, sbe_pend_q, dbe_pend_q, sbe_clr, dbe_clr;
  logic          ien_q, imode_q, retrig_q;
  logic          wr_ctrl, wr_istat;
  logic          unused_wdata;

  assign wr_ctrl  = reg_we_i && reg_addr_i == OFS_CTRL;
  assign wr_istat = reg_we_i && reg_addr_i == OFS_ISTAT;
  assign unused_wdata = ^reg_wdata_i;

  for (genvar p = 0; p < NP; p++) begin : g_bits
    assign init_start_o[p] = wr_ctrl && reg_wdata_i[START_BIT + p];
    assign sbe_clr[p]      = wr_istat && reg_wdata_i[p];
    assign dbe_clr[p]      = wr_istat && reg_wdata_i[DBE_BIT + p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_en_q   <= '0;
      ien_q      <= 1'b0;
      imode_q    <= 1'b0;
      sbe_pend_q <= '0;
      dbe_pend_q <= '0;
      retrig_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ecc_en_q <= reg_wdata_i[NP-1:0];
      if (reg_we_i && reg_addr_i == OFS_IEN) ien_q <= reg_wdata_i[0];
      else if (reg_we_i && reg_addr_i == OFS_IEN_SET && reg_wdata_i[0]) ien_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFS_IEN_CLR && reg_wdata_i[0]) ien_q <= 1'b0;
      if (reg_we_i && reg_addr_i == OFS_IMODE) imode_q <= reg_wdata_i[0];
      // new event wins over a same-cycle clear
      sbe_pend_q <= (sbe_pend_q & ~sbe_clr) | sbe_i;
      dbe_pend_q <= (dbe_pend_q & ~dbe_clr) | dbe_i;
      retrig_q   <= imode_q && ien_q && |(sbe_i & sbe_pend_q);
    end
  end

  assign irq_o    = ((ien_q && |sbe_pend_q) || |dbe_pend_q) && !retrig_q;
  assign ecc_en_o = ecc_en_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CTRL:  reg_rdata_o[NP-1:0] = ecc_en_q;
      OFS_DONE:  for (int p = 0; p < NP; p++) reg_rdata_o[8*p] = done_i[p];
      OFS_IEN:   reg_rdata_o[0] = ien_q;
      OFS_IMODE: reg_rdata_o[0] = imode_q;
      OFS_ISTAT: begin
        reg_rdata_o[NP-1:0]              = sbe_pend_q;
        reg_rdata_o[DBE_BIT +: NP]       = dbe_pend_q;
      end
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_ram.sv
module ecc_ram
  import ecc_ram_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             reg_we_i,
  input  logic [5:0]                       reg_addr_i,
  input  logic [31:0]                      reg_wdata_i,
  output logic [31:0]                      reg_rdata_o,
  input  logic [NUM_PORTS-1:0]             req_i,
  input  logic [NUM_PORTS-1:0]             we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS-1:0][31:0]       wdata_i,
  output logic [NUM_PORTS-1:0]             ready_o,
  output logic [NUM_PORTS-1:0]             rvalid_o,
  output logic [NUM_PORTS-1:0][31:0]       rdata_o,
  output logic                             irq_o
);
  logic [NUM_PORTS-1:0] ecc_en, init_start, done, sbe, dbe;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ecc_ram_port #(.DEPTH(DEPTH), .AW(ADDR_W)) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ecc_en_i     (ecc_en[p]),
      .init_start_i (init_start[p]),
      .req_i        (req_i[p]),
      .we_i         (we_i[p]),
      .addr_i       (addr_i[p]),
      .wdata_i      (wdata_i[p]),
      .ready_o      (ready_o[p]),
      .rvalid_o     (rvalid_o[p]),
      .rdata_o      (rdata_o[p]),
      .sbe_o        (sbe[p]),
      .dbe_o        (dbe[p]),
      .done_o       (done[p])
    );
  end

  ecc_ram_regs #(.NP(NUM_PORTS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .done_i       (done),
    .sbe_i        (sbe),
    .dbe_i        (dbe),
    .ecc_en_o     (ecc_en),
    .init_start_o (init_start),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/ecc_ram_chk.sv
module ecc_ram_chk #(
  parameter int NUM_PORTS = 2,
  parameter int DEPTH     = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [5:0]           reg_addr_i,
  input logic [31:0]          reg_wdata_i,
  input logic [NUM_PORTS-1:0] req_i,
  input logic [NUM_PORTS-1:0] we_i,
  input logic [NUM_PORTS-1:0] ready_o,
  input logic [NUM_PORTS-1:0] rvalid_o,
  input logic                 irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 2);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    logic [CNT_W-1:0] busy_cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_cnt_q <= '0;
      else if (ready_o[p]) busy_cnt_q <= '0;
      else if (busy_cnt_q <= CNT_W'(DEPTH)) busy_cnt_q <= busy_cnt_q + 1'b1;
    end

    a_r3_pass_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ready_o[p] |-> busy_cnt_q < CNT_W'(DEPTH));

    a_r3_start_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == 6'h08 && reg_wdata_i[16 + p]) |=> !ready_o[p]);

    a_r2_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[p] && !we_i[p] && ready_o[p]) |=> rvalid_o[p]);

    a_r3_stalled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i[p] && !we_i[p] && ready_o[p]) |=> !rvalid_o[p]);
  end

  a_r9_clear_all_quiets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 6'h20 && (&reg_wdata_i) && rvalid_o == '0) |=> !irq_o);
endmodule

bind ecc_ram ecc_ram_chk #(.NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .irq_o       (irq_o)
);

// File: tb/ecc_ram_test.sv
module ecc_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] req = '0, we = '0, ready, rvalid;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] ctrl_sh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_ram #(.NUM_PORTS(NP), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    ctrl_sh = v; reg_wr(6'h08, v);
  endtask

  task automatic mem_wr(input int p, input logic [AW-1:0] a, input logic [31:0] d);
    req[p] = 1'b1; we[p] = 1'b1; addr[p] = a; wdata[p] = d;
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
  endtask

  task automatic mem_rd(input int p, input logic [AW-1:0] a, output logic [31:0] d);
    req[p] = 1'b1; we[p] = 1'b0; addr[p] = a;
    @(negedge clk);
    req[p] = 1'b0;
    chk("R2 rvalid one cycle after request", 32'(rvalid[p]), 32'd1);
    d = rdata[p];
  endtask

  // run a zero-fill pass, probe a read while busy, optionally re-request mid-pass
  task automatic run_init(input int p, input bit reissue, output int low);
    logic [31:0] v;
    reg_wr(6'h08, ctrl_sh | (32'h1 << (16 + p)));
    reg_rd(6'h0C, v);
    chk("R4 start clears done flag", v[8*p], 1'b0);
    low = 0;
    req[p] = 1'b1; we[p] = 1'b0; addr[p] = '0;
    while (!ready[p] && low < 4*DEPTH) begin
      low++;
      if (reissue && low == 3) begin
        req[p] = 1'b0;
        reg_wr(6'h08, ctrl_sh | (32'h1 << (16 + p)));
      end else @(negedge clk);
      if (low == 1) begin
        chk("R3 request ignored while busy", 32'(rvalid[p]), 32'd0);
        req[p] = 1'b0;
      end
    end
    reg_rd(6'h0C, v);
    chk("R4 done flag after pass", v[8*p], 1'b1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (uut.ready_o[p]) ;
    chk("R1 ready after reset", 32'(ready), 32'(2'b11));
    chk("R1 irq after reset", 32'(irq), 32'd0);
    reg_rd(6'h08, v); chk("R1 ctrl reset", v, 0);
    reg_rd(6'h0C, v); chk("R1 done reset", v, 0);
    reg_rd(6'h10, v); chk("R1 ien reset", v, 0);
    reg_rd(6'h1C, v); chk("R1 mode reset", v, 0);
    reg_rd(6'h20, v); chk("R1 status reset", v, 0);
  endtask

  task automatic t_init();
    int low;
    logic [31:0] v;
    set_ctrl(32'h3);
    mem_wr(0, 4'd5, 32'hDEADBEEF);
    mem_rd(0, 4'd5, v); chk("R2 write/read data", v, 32'hDEADBEEF);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R2 no error flag", v, 0);
    reg_rd(6'h08, v); chk("R11 enables read back", v, 32'h3);
    set_ctrl(32'h0);
    run_init(0, 1'b0, low); chk("R3 pass length A", low, DEPTH);
    run_init(1, 1'b1, low); chk("R4 re-request ignored, length B", low, DEPTH);
    run_init(0, 1'b0, low); chk("R4 repeat pass A", low, DEPTH);
    reg_rd(6'h0C, v); chk("R4 both flags", v, 32'h101);
    set_ctrl(32'h3);
    mem_rd(0, 4'd5, v); chk("R3 cleared word reads zero", v, 0);
    mem_rd(1, 4'd9, v); chk("R3 port B word zero", v, 0);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R3 no flags after fill", v, 0);
    chk("R3 irq low after fill", 32'(irq), 0);
  endtask

  task automatic t_sbe();
    logic [31:0] v;
    set_ctrl(32'h0);
    mem_wr(0, 4'd3, 32'h0000_0010);
    mem_rd(0, 4'd3, v); chk("R5 raw read when disabled", v, 32'h10);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R5 no flag when disabled", v, 0);
    set_ctrl(32'h3);
    reg_rd(6'h08, v); chk("R11 start bits read zero", v, 32'h3);
    mem_rd(0, 4'd3, v); chk("R6 corrected data", v, 0);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R6 single pending port A", v, 32'h1);
    chk("R8 irq masked when disabled", 32'(irq), 0);
    reg_wr(6'h14, 32'h1);
    chk("R8 set alias raises irq", 32'(irq), 1);
    reg_rd(6'h10, v); chk("R8 enable reads one", v, 1);
    reg_wr(6'h18, 32'h1);
    chk("R8 clear alias drops irq", 32'(irq), 0);
    reg_wr(6'h10, 32'h1);
    chk("R8 direct write enables", 32'(irq), 1);
    reg_wr(6'h20, 32'h0);
    reg_rd(6'h20, v); chk("R9 zero write keeps bit", v, 32'h1);
    reg_wr(6'h20, 32'h1);
    reg_rd(6'h20, v); chk("R9 one clears bit", v, 0);
    chk("R9 irq gone", 32'(irq), 0);
  endtask

  task automatic t_dbe();
    logic [31:0] v;
    reg_wr(6'h10, 32'h0);
    set_ctrl(32'h0);
    mem_wr(0, 4'd4, 32'h0000_0003);
    mem_wr(1, 4'd7, 32'h8000_0001);
    set_ctrl(32'h3);
    mem_rd(0, 4'd4, v);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R7 double pending port A", v, 32'h100);
    chk("R7 irq despite disable", 32'(irq), 1);
    mem_rd(1, 4'd7, v);
    @(negedge clk);
    reg_rd(6'h20, v); chk("R7 double pending port B", v, 32'h300);
    reg_wr(6'h20, 32'hFFFF_FFFF);
    chk("R9 clear all", 32'(irq), 0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    reg_wr(6'h10, 32'h1);
    reg_wr(6'h1C, 32'h0);
    mem_rd(0, 4'd3, v);
    @(negedge clk); chk("R6 first single raises irq", 32'(irq), 1);
    mem_rd(0, 4'd3, v);
    @(negedge clk); chk("R10 mode 0 holds irq", 32'(irq), 1);
    @(negedge clk); chk("R10 mode 0 holds irq later", 32'(irq), 1);
    reg_wr(6'h1C, 32'h1);
    reg_rd(6'h1C, v); chk("R10 mode reads back", v, 1);
    mem_rd(0, 4'd3, v);
    chk("R10 irq before retrigger", 32'(irq), 1);
    @(negedge clk); chk("R10 mode 1 one-cycle drop", 32'(irq), 0);
    @(negedge clk); chk("R10 mode 1 irq back", 32'(irq), 1);
    reg_wr(6'h20, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_sbe();
    t_dbe();
    t_mode();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule